// File: doc/BRIEF.md
# Branch Target Buffer

A small fully associative table that remembers where conditional branches went the last time they executed. Every fetch address is compared against all stored branch addresses in the same cycle; on a match the block raises `hit` and drives the remembered destination on `pred_target`, otherwise it proposes the sequential address (fetch address plus four).

The table learns lazily. The cycle after a fetch, the decode stage presents the 7-bit opcode of that instruction. Two cycles after the fetch, the resolution port reports the instruction's address and its real next address. The fetch-stage hit result, the index that hit and the decode-stage branch flag travel down an internal two-stage pipeline alongside the instruction. Resolution therefore uses that instruction's own flags. A branch that missed at fetch gets a new entry; an entry that predicted the wrong destination is dropped outright rather than corrected; everything else leaves the table alone.

For a taken branch the resolved next address is the branch address plus the immediate times four; for a not-taken branch it is the branch address plus four. The block stores whichever value resolution reports.

Top module: `branch_target_buffer`

## Requirements
- R1: `hit` is 1 exactly when a valid entry holds an address equal to `fetch_pc`; `pred_target` is then that entry's stored next address.
- R2: When `hit` is 0, `pred_target` equals `fetch_pc + 4`.
- R3: The instruction fetched in cycle t supplies its opcode on `dec_opcode` in cycle t+1 and is resolved in cycle t+2. It counts as a branch when the opcode is 7'b1100011. If it missed at fetch and is a branch, it is allocated with `res_pc` as key and `res_next_pc` as stored target. The new entry hits from the following cycle.
- R4: A resolved instruction that missed at fetch and whose opcode is not 7'b1100011 leaves the table unchanged.
- R5: A resolved instruction that hit at fetch keeps its entry when `res_next_pc` equals the stored target.
- R6: A resolved instruction that hit at fetch has its entry invalidated when `res_next_pc` differs from the stored target. No new entry is created by that same resolution.
- R7: While `res_valid` is 0, the table is not modified.
- R8: An address already present at resolution time is never allocated a second time, even if its fetch missed.
- R9: Allocation fills the lowest-numbered invalid entry first. When all entries are valid, the victim is chosen round-robin, starting at entry 0 after reset and advancing by one after each eviction.
- R10: An invalid entry is always preferred over the round-robin victim, and such an allocation does not move the round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction is fetched this cycle |
| fetch_pc | input | XLEN | Fetch address |
| hit | output | 1 | Fetch address found in the table |
| pred_target | output | XLEN | Predicted next fetch address |
| dec_opcode | input | 7 | Opcode of the instruction fetched one cycle earlier |
| res_valid | input | 1 | Resolution of the instruction fetched two cycles earlier |
| res_pc | input | XLEN | Address of the resolving instruction |
| res_next_pc | input | XLEN | Actual next address of the resolving instruction |

## Verification
The hardest situation to reach is two copies of the same branch in flight together. Both miss at fetch because the first has not resolved yet, so the second resolution finds the address already present. The bench fetches the same address on two consecutive cycles and then forces a target mismatch. A single invalidation must then leave the address missing, which exposes any duplicate entry. Victim selection is the second hard case. It is reached by filling the table, evicting twice, and then opening a hole with a mismatch. The stimulus then checks which older entries survive the next two allocations.

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
  parameter int XLEN    = 32,
  parameter int ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_pc,
  output logic            hit,
  output logic [XLEN-1:0] pred_target,
  input  logic [6:0]      dec_opcode,
  input  logic            res_valid,
  input  logic [XLEN-1:0] res_pc,
  input  logic [XLEN-1:0] res_next_pc
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [6:0] BRANCH_OP = 7'b1100011;

  logic [ENTRIES-1:0] vld;
  logic [XLEN-1:0]    key_q [ENTRIES];
  logic [XLEN-1:0]    dst_q [ENTRIES];
  logic [IW-1:0]      rr_ptr;

  logic [ENTRIES-1:0] f_match, r_match;
  logic [IW-1:0]      f_idx, free_idx, alloc_idx;

  logic          d_valid, d_hit;
  logic [IW-1:0] d_idx;
  logic          r_valid, r_hit, r_br;
  logic [IW-1:0] r_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign f_match[g] = vld[g] && (key_q[g] == fetch_pc);
    assign r_match[g] = vld[g] && (key_q[g] == res_pc);
  end

  always_comb begin
    f_idx    = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (f_match[i]) f_idx = IW'(i);
      if (!vld[i])    free_idx = IW'(i);
    end
  end

  assign hit         = |f_match;
  assign pred_target = hit ? dst_q[f_idx] : fetch_pc + XLEN'(4);

  logic full, res_go, do_alloc, do_kill;
  assign full      = &vld;
  assign alloc_idx = full ? rr_ptr : free_idx;
  assign res_go    = res_valid && r_valid;
  assign do_alloc  = res_go && !r_hit && r_br && !(|r_match);
  assign do_kill   = res_go && r_hit && vld[r_idx] && (key_q[r_idx] == res_pc)
                     && (dst_q[r_idx] != res_next_pc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_hit   <= 1'b0;
      d_idx   <= '0;
      r_valid <= 1'b0;
      r_hit   <= 1'b0;
      r_br    <= 1'b0;
      r_idx   <= '0;
    end else begin
      d_valid <= fetch_valid;
      d_hit   <= fetch_valid && hit;
      d_idx   <= f_idx;
      r_valid <= d_valid;
      r_hit   <= d_hit;
      r_br    <= d_valid && (dec_opcode == BRANCH_OP);
      r_idx   <= d_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      rr_ptr <= '0;
    end else begin
      if (do_kill) vld[r_idx] <= 1'b0;
      if (do_alloc) begin
        vld[alloc_idx] <= 1'b1;
        if (full) rr_ptr <= rr_ptr + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      key_q[alloc_idx] <= res_pc;
      dst_q[alloc_idx] <= res_next_pc;
    end
  end

  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(f_match));

  a_r3_alloc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc |=> vld[$past(alloc_idx)] && key_q[$past(alloc_idx)] == $past(res_pc)
                 && dst_q[$past(alloc_idx)] == $past(res_next_pc));

  a_r6_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    do_kill |=> !vld[$past(r_idx)]);

  a_r4_nonbranch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (res_go && !r_hit && !r_br) |=> $stable(vld));

  a_r7_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(vld) && $stable(rr_ptr));

  a_r10_pointer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && !full) |=> $stable(rr_ptr));

endmodule

// File: tb/branch_target_buffer_tb_top.sv
module branch_target_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] OP_BR  = 7'b1100011;
  localparam logic [6:0] OP_ALU = 7'b0010011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        hit;
  logic [31:0] pred_target;
  logic [6:0]  dec_opcode = '0;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic [31:0] res_next_pc = '0;

  int checks = 0;
  int errors = 0;

  bit          q_hit [$];
  logic [31:0] q_tgt [$];
  string       q_req [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .hit(hit), .pred_target(pred_target), .dec_opcode(dec_opcode),
    .res_valid(res_valid), .res_pc(res_pc), .res_next_pc(res_next_pc)
  );

  always @(negedge clk) begin
    if (rst_n && fetch_valid) begin
      checks++;
      if (q_hit.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: fetch of %h with nothing expected", fetch_pc);
      end else begin
        automatic bit    eh = q_hit.pop_front();
        automatic logic [31:0] et = q_tgt.pop_front();
        automatic string rq = q_req.pop_front();
        if (hit !== eh || pred_target !== et) begin
          errors++;
          $display("FAIL %s: pc %h hit %b target %h, expected hit %b target %h",
                   rq, fetch_pc, hit, pred_target, eh, et);
        end
      end
    end
  end

  task automatic step(input bit fv, input logic [31:0] fpc, input logic [6:0] op,
                      input bit rv, input logic [31:0] rpc, input logic [31:0] rnpc,
                      input bit eh, input logic [31:0] et, input string rq);
    fetch_valid = fv; fetch_pc = fpc; dec_opcode = op;
    res_valid = rv; res_pc = rpc; res_next_pc = rnpc;
    if (fv) begin q_hit.push_back(eh); q_tgt.push_back(et); q_req.push_back(rq); end
    @(posedge clk); #1;
  endtask

  task automatic run(input logic [31:0] pc, input logic [6:0] op, input logic [31:0] nxt,
                     input bit eh, input logic [31:0] et, input string rq, input bit rv = 1'b1);
    step(1, pc, 7'h0, 0, '0, '0, eh, et, rq);
    step(0, '0, op, 0, '0, '0, 0, '0, rq);
    step(0, '0, 7'h0, rv, pc, nxt, 0, '0, rq);
  endtask

  function automatic logic [31:0] taken(input logic [31:0] pc, input int imm);
    return pc + 32'(imm * 4);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset state: empty table falls through
    run(32'h40, OP_ALU, 32'h44, 0, 32'h44, "R2");
    // R3 allocation of a missed branch, then R1 / R5 hits keep it
    run(32'h40, OP_BR, taken(32'h40, -4), 0, 32'h44, "R3");
    run(32'h40, OP_BR, 32'h30, 1, 32'h30, "R1");
    run(32'h40, OP_BR, 32'h30, 1, 32'h30, "R5");
    // R4 non-branch miss leaves table alone
    run(32'h80, OP_ALU, 32'h84, 0, 32'h84, "R4");
    run(32'h80, OP_ALU, 32'h84, 0, 32'h84, "R4");
    // R6 mismatch drops the entry, no realloc by that resolution
    run(32'h40, OP_BR, 32'h44, 1, 32'h30, "R6");
    run(32'h40, OP_BR, 32'h44, 0, 32'h44, "R6");
    run(32'h40, OP_BR, 32'h44, 1, 32'h44, "R3");
    // R7 resolution not valid: nothing allocated
    run(32'h90, OP_BR, 32'h50, 0, 32'h94, "R7", 1'b0);
    run(32'h90, OP_ALU, 32'h94, 0, 32'h94, "R7");
    // R8 two overlapping copies of the same branch
    step(1, 32'hA0, 7'h0,  0, '0, '0, 0, 32'hA4, "R8");
    step(1, 32'hA0, OP_BR, 0, '0, '0, 0, 32'hA4, "R8");
    step(0, '0,     OP_BR, 1, 32'hA0, 32'hC0, 0, '0, "R8");
    step(0, '0,     7'h0,  1, 32'hA0, 32'hC0, 0, '0, "R8");
    run(32'hA0, OP_BR, 32'hA4, 1, 32'hC0, "R8");
    run(32'hA0, OP_ALU, 32'hA4, 0, 32'hA4, "R8");
    // R9 fill slots 1..7 (slot 0 holds 0x40)
    for (int i = 0; i < 7; i++)
      run(32'h200 + 32'(8*i), OP_BR, 32'h300 + 32'(8*i), 0, 32'h204 + 32'(8*i), "R9");
    for (int i = 0; i < 7; i++)
      run(32'h200 + 32'(8*i), OP_BR, 32'h300 + 32'(8*i), 1, 32'h300 + 32'(8*i), "R9");
    run(32'h40, OP_BR, 32'h44, 1, 32'h44, "R9");
    // R9 round-robin evicts slot 0 then slot 1
    run(32'h400, OP_BR, 32'h480, 0, 32'h404, "R9");
    run(32'h40, OP_ALU, 32'h44, 0, 32'h44, "R9");
    run(32'h200, OP_BR, 32'h300, 1, 32'h300, "R9");
    run(32'h408, OP_BR, 32'h488, 0, 32'h40C, "R9");
    run(32'h200, OP_ALU, 32'h204, 0, 32'h204, "R9");
    run(32'h208, OP_BR, 32'h308, 1, 32'h308, "R9");
    // R10 hole in slot 5 is used before the pointer (now at slot 2)
    run(32'h220, OP_BR, 32'h224, 1, 32'h320, "R10");
    run(32'h500, OP_BR, 32'h580, 0, 32'h504, "R10");
    run(32'h208, OP_BR, 32'h308, 1, 32'h308, "R10");
    run(32'h508, OP_BR, 32'h588, 0, 32'h50C, "R10");
    run(32'h208, OP_ALU, 32'h20C, 0, 32'h20C, "R10");
    run(32'h210, OP_BR, 32'h310, 1, 32'h310, "R10");
    run(32'h500, OP_BR, 32'h580, 1, 32'h580, "R10");
    run(32'h508, OP_BR, 32'h588, 1, 32'h588, "R10");
    run(32'h400, OP_BR, 32'h480, 1, 32'h480, "R1");

    repeat (2) @(posedge clk);
    if (q_hit.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d expected fetches unmatched, expected 0", q_hit.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule